// File: doc/BRIEF.md
# Delay-Line Position Packer

This block takes one event at a time from a four-ended delay-line detector readout: the arrival times at both ends of the X line and of the Y line, plus a time-of-flight stamp. From these it forms an X position, a Y position and a time value, trims each to a programmed number of bits and concatenates the three into a single 32-bit word. Words are queued in a 16-entry buffer with first-word fall-through, so the capture logic can keep producing events at its own rate while a downstream reader drains at another.

The split of the 32 bits between the three fields is held in a configuration register. A write is taken only when the three widths add up to exactly 32; any other write leaves the active split unchanged. When the buffer is full the event input stops accepting, and a sticky flag records that an event was offered and refused.

Top module: `pos_packer`

## Requirements
- R1: After reset, rd_valid_o is 0, ev_ready_o is 1, overflow_o is 0, and the active widths read back as X=11, Y=11, Z=10.
- R2: For an accepted event with timestamps of TW bits (default 16), the X value is x1 - x2 + 2^TW as a (TW+1)-bit unsigned number, Y is y1 - y2 + 2^TW likewise, and Z is the TW-bit time-of-flight value.
- R3: Each value is reduced to its programmed width w by keeping its w most significant bits; when w exceeds the value's width the value fills the top bits of the field and the rest are 0; a width of 0 gives an empty field.
- R4: The word holds X in the top wx bits, Y in the next wy bits and Z in the lowest wz bits.
- R5: A configuration write (cfg_we_i=1) whose three widths sum to exactly 32 becomes active and visible on cfg_w*_o from the next cycle.
- R6: A configuration write whose widths do not sum to 32 is ignored; the previous widths remain active and visible.
- R7: An event is accepted in a cycle where ev_valid_i and ev_ready_o are both 1; if the buffer was empty, its word appears on rd_data_o with rd_valid_o=1 in the next cycle, with no read request needed.
- R8: Words leave in acceptance order; rd_en_i with rd_valid_o=1 removes the head word, and rd_data_o stays stable while rd_valid_o=1 and no read occurs.
- R9: The buffer holds 16 words; ev_ready_o is 0 exactly while 16 words are held.
- R10: overflow_o becomes 1 the cycle after ev_valid_i=1 is seen with ev_ready_o=0, and stays 1 until reset.
- R11: An event uses the widths active in its own acceptance cycle; a configuration write in the same cycle affects only later events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Event offered |
| ev_ready_o | output | 1 | Event can be taken (buffer not full) |
| x1_i | input | TW | X line, first end time |
| x2_i | input | TW | X line, second end time |
| y1_i | input | TW | Y line, first end time |
| y2_i | input | TW | Y line, second end time |
| tof_i | input | TW | Time-of-flight stamp |
| cfg_we_i | input | 1 | Width configuration write strobe |
| cfg_wx_i | input | 6 | Requested X width |
| cfg_wy_i | input | 6 | Requested Y width |
| cfg_wz_i | input | 6 | Requested Z width |
| cfg_wx_o | output | 6 | Active X width |
| cfg_wy_o | output | 6 | Active Y width |
| cfg_wz_o | output | 6 | Active Z width |
| rd_en_i | input | 1 | Remove head word |
| rd_valid_o | output | 1 | Head word present |
| rd_data_o | output | 32 | Head word |
| overflow_o | output | 1 | Sticky refused-event flag |

## Verification
A directed event with known timestamps under the reset widths pins down the sign offset and field order, since a missing offset or swapped fields change a hand-computed word. Extreme splits (all 32 bits to X, a zero-width Z) separate truncation from zero-padding and expose off-by-one shifts. A fill with no reads followed by refused offers tells apart a full buffer that drops silently from one that flags and holds ready low, and a long random mix of offers, reads and valid or invalid width writes, compared against a queue model every cycle, catches ordering faults, wrong same-cycle configuration timing and rejection errors.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int WORD_W = 32;
  localparam int WID_W  = 6;

  typedef struct packed {
    logic [WID_W-1:0] wx;
    logic [WID_W-1:0] wy;
    logic [WID_W-1:0] wz;
  } widths_t;

  // keep the top w bits of a left-aligned value
  function automatic logic [WORD_W-1:0] take_msbs(logic [WORD_W-1:0] aligned,
                                                   logic [WID_W-1:0] w);
    if (w == '0) return '0;
    return aligned >> (7'd32 - {1'b0, w});
  endfunction
endpackage

// File: rtl/pp_cfg_reg.sv
module pp_cfg_reg
  import pp_pkg::*;
#(
  parameter int RST_WX = 11,
  parameter int RST_WY = 11,
  parameter int RST_WZ = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WID_W-1:0] wx_i,
  input  logic [WID_W-1:0] wy_i,
  input  logic [WID_W-1:0] wz_i,
  output widths_t          cfg_o
);
  logic [7:0] sum;
  logic       ok;

  assign sum = {2'b0, wx_i} + {2'b0, wy_i} + {2'b0, wz_i};
  assign ok  = (sum == 8'd32);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.wx <= WID_W'(RST_WX);
      cfg_o.wy <= WID_W'(RST_WY);
      cfg_o.wz <= WID_W'(RST_WZ);
    end else if (we_i && ok) begin
      cfg_o.wx <= wx_i;
      cfg_o.wy <= wy_i;
      cfg_o.wz <= wz_i;
    end
  end
endmodule

// File: rtl/pp_field_calc.sv
module pp_field_calc
  import pp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic [TW-1:0]     x1_i,
  input  logic [TW-1:0]     x2_i,
  input  logic [TW-1:0]     y1_i,
  input  logic [TW-1:0]     y2_i,
  input  logic [TW-1:0]     tof_i,
  input  widths_t           cfg_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int DW = TW + 1;
  localparam logic [DW-1:0] OFS = DW'(1) << TW;

  logic [TW-1:0]     end_a [2];
  logic [TW-1:0]     end_b [2];
  logic [DW-1:0]     diff  [2];
  logic [WORD_W-1:0] algn  [2];

  assign end_a[0] = x1_i;
  assign end_b[0] = x2_i;
  assign end_a[1] = y1_i;
  assign end_b[1] = y2_i;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    // offset keeps the difference non-negative
    assign diff[g] = {1'b0, end_a[g]} - {1'b0, end_b[g]} + OFS;
    assign algn[g] = {diff[g], {(WORD_W-DW){1'b0}}};
  end

  logic [WORD_W-1:0] z_algn, fx, fy, fz;
  logic [6:0]        sh_x;

  assign z_algn = {tof_i, {(WORD_W-TW){1'b0}}};
  assign fx     = take_msbs(algn[0], cfg_i.wx);
  assign fy     = take_msbs(algn[1], cfg_i.wy);
  assign fz     = take_msbs(z_algn,  cfg_i.wz);
  assign sh_x   = {1'b0, cfg_i.wy} + {1'b0, cfg_i.wz};
  assign word_o = (fx << sh_x) | (fy << cfg_i.wz) | fz;
endmodule

// File: rtl/pp_fifo.sv
module pp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rptr];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/pos_packer.sv
module pos_packer
  import pp_pkg::*;
#(
  parameter int TW         = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  output logic              ev_ready_o,
  input  logic [TW-1:0]     x1_i,
  input  logic [TW-1:0]     x2_i,
  input  logic [TW-1:0]     y1_i,
  input  logic [TW-1:0]     y2_i,
  input  logic [TW-1:0]     tof_i,
  input  logic              cfg_we_i,
  input  logic [WID_W-1:0]  cfg_wx_i,
  input  logic [WID_W-1:0]  cfg_wy_i,
  input  logic [WID_W-1:0]  cfg_wz_i,
  output logic [WID_W-1:0]  cfg_wx_o,
  output logic [WID_W-1:0]  cfg_wy_o,
  output logic [WID_W-1:0]  cfg_wz_o,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              overflow_o
);
  widths_t           cfg;
  logic [WORD_W-1:0] word;
  logic              full, empty;

  pp_cfg_reg u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .wx_i  (cfg_wx_i),
    .wy_i  (cfg_wy_i),
    .wz_i  (cfg_wz_i),
    .cfg_o (cfg)
  );

  pp_field_calc #(.TW(TW)) u_calc (
    .x1_i  (x1_i),
    .x2_i  (x2_i),
    .y1_i  (y1_i),
    .y2_i  (y2_i),
    .tof_i (tof_i),
    .cfg_i (cfg),
    .word_o(word)
  );

  pp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (ev_valid_i),
    .wdata_i(word),
    .pop_i  (rd_en_i),
    .rdata_o(rd_data_o),
    .full_o (full),
    .empty_o(empty)
  );

  assign ev_ready_o = !full;
  assign rd_valid_o = !empty;
  assign cfg_wx_o   = cfg.wx;
  assign cfg_wy_o   = cfg.wy;
  assign cfg_wz_o   = cfg.wz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  overflow_o <= 1'b0;
    else if (ev_valid_i && full)  overflow_o <= 1'b1;
  end
endmodule

// File: rtl/pos_packer_chk.sv
module pos_packer_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ev_valid_i,
  input logic        ev_ready_o,
  input logic        cfg_we_i,
  input logic [5:0]  cfg_wx_i,
  input logic [5:0]  cfg_wy_i,
  input logic [5:0]  cfg_wz_i,
  input logic [5:0]  cfg_wx_o,
  input logic [5:0]  cfg_wy_o,
  input logic [5:0]  cfg_wz_o,
  input logic        rd_en_i,
  input logic        rd_valid_o,
  input logic [31:0] rd_data_o,
  input logic        overflow_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ;
  logic          in_ok;

  assign in_ok = ({2'b0, cfg_wx_i} + {2'b0, cfg_wy_i} + {2'b0, cfg_wz_i}) == 8'd32;

  // occupancy seen from the ports only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ <= '0;
    else occ <= occ + CW'(ev_valid_i && ev_ready_o) - CW'(rd_en_i && rd_valid_o);
  end

  p_ready_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_ready_o == (occ != CW'(DEPTH)));

  p_valid_occ_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o == (occ != '0));

  p_head_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_en_i) |=> (rd_valid_o && $stable(rd_data_o)));

  p_ovf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !ev_ready_o) |=> overflow_o);

  p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_cfg_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && in_ok) |=> (cfg_wx_o == $past(cfg_wx_i) && cfg_wy_o == $past(cfg_wy_i)
                             && cfg_wz_o == $past(cfg_wz_i)));

  p_cfg_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && in_ok) |=> ($stable(cfg_wx_o) && $stable(cfg_wy_o) && $stable(cfg_wz_o)));
endmodule

bind pos_packer pos_packer_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ev_valid_i(ev_valid_i),
  .ev_ready_o(ev_ready_o),
  .cfg_we_i  (cfg_we_i),
  .cfg_wx_i  (cfg_wx_i),
  .cfg_wy_i  (cfg_wy_i),
  .cfg_wz_i  (cfg_wz_i),
  .cfg_wx_o  (cfg_wx_o),
  .cfg_wy_o  (cfg_wy_o),
  .cfg_wz_o  (cfg_wz_o),
  .rd_en_i   (rd_en_i),
  .rd_valid_o(rd_valid_o),
  .rd_data_o (rd_data_o),
  .overflow_o(overflow_o)
);

// File: tb/pos_packer_test.sv
`timescale 1ns/1ps
module pos_packer_test;
  localparam int TW  = 16;
  localparam int DEP = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ev_valid_i = 0, cfg_we_i = 0, rd_en_i = 0;
  logic [TW-1:0] x1_i = 0, x2_i = 0, y1_i = 0, y2_i = 0, tof_i = 0;
  logic [5:0] cfg_wx_i = 0, cfg_wy_i = 0, cfg_wz_i = 0;
  logic [5:0] cfg_wx_o, cfg_wy_o, cfg_wz_o;
  logic ev_ready_o, rd_valid_o, overflow_o;
  logic [31:0] rd_data_o;

  always #2.5 clk_i = ~clk_i;

  pos_packer #(.TW(TW), .FIFO_DEPTH(DEP)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference state
  bit [31:0] q[$];
  int m_wx = 11, m_wy = 11, m_wz = 10;
  bit m_ovf = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic longint fld(longint v, int srcw, int w);
    longint left;
    if (w == 0) return 0;
    left = v << (32 - srcw);
    return left >> (32 - w);
  endfunction

  function automatic bit [31:0] ref_word(int a1, int a2, int b1, int b2, int t);
    longint dx, dy, r;
    dx = a1 - a2 + 65536;
    dy = b1 - b2 + 65536;
    r = (fld(dx, 17, m_wx) << (m_wy + m_wz)) | (fld(dy, 17, m_wy) << m_wz) | fld(t, 16, m_wz);
    return r[31:0];
  endfunction

  task automatic compare();
    chk(cur_req, "ev_ready_o", ev_ready_o, q.size() < DEP);
    chk(cur_req, "rd_valid_o", rd_valid_o, q.size() > 0);
    if (q.size() > 0) chk(cur_req, "rd_data_o", rd_data_o, q[0]);
    chk(cur_req, "overflow_o", overflow_o, m_ovf);
    chk(cur_req, "cfg_w*_o", {cfg_wx_o, cfg_wy_o, cfg_wz_o}, {6'(m_wx), 6'(m_wy), 6'(m_wz)});
  endtask

  // one cycle: check state, drive inputs, advance model to the next edge
  task automatic step(bit v, int a1, int a2, int b1, int b2, int t,
                      bit rd, bit we, int wx, int wy, int wz);
    bit rdy, acc;
    bit [31:0] w;
    @(negedge clk_i);
    compare();
    ev_valid_i = v; x1_i = a1[15:0]; x2_i = a2[15:0]; y1_i = b1[15:0]; y2_i = b2[15:0];
    tof_i = t[15:0]; rd_en_i = rd; cfg_we_i = we;
    cfg_wx_i = wx[5:0]; cfg_wy_i = wy[5:0]; cfg_wz_i = wz[5:0];
    rdy = q.size() < DEP;
    acc = v && rdy;
    w = ref_word(a1, a2, b1, b2, t);  // R11: widths before this cycle's write
    if (rd && q.size() > 0) void'(q.pop_front());
    if (acc) q.push_back(w);
    if (v && !rdy) m_ovf = 1;
    if (we && (wx + wy + wz == 32)) begin m_wx = wx; m_wy = wy; m_wz = wz; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    cur_req = "R1";
    @(negedge clk_i);
    chk("R1", "rd_valid_o", rd_valid_o, 0);
    chk("R1", "ev_ready_o", ev_ready_o, 1);
    chk("R1", "overflow_o", overflow_o, 0);
    chk("R1", "widths", {cfg_wx_o, cfg_wy_o, cfg_wz_o}, {6'd11, 6'd11, 6'd10});

    // R2 R4 R7 directed word with default split
    cur_req = "R7";
    step(1, 100, 40, 0, 0, 16'hFFFF, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2/R4", "directed word", rd_data_o, 32'h801003FF);
    cur_req = "R2";
    step(1, 5, 9, 60000, 3, 1234, 1, 0, 0, 0, 0);
    step(1, 0, 65535, 65535, 0, 0, 1, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    // R3 extreme splits
    cur_req = "R3";
    step(0, 0, 0, 0, 0, 0, 1, 1, 32, 0, 0);
    step(1, 7, 3, 1, 1, 99, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 17, 15, 0);
    step(1, 300, 2, 9, 40000, 77, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 32);
    step(1, 1, 2, 3, 4, 16'hA5C3, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    // R6 rejected writes, then R5 valid one
    cur_req = "R6";
    step(0, 0, 0, 0, 0, 0, 0, 1, 10, 10, 10);
    step(0, 0, 0, 0, 0, 0, 0, 1, 30, 30, 30);
    step(1, 9, 1, 8, 2, 500, 0, 1, 0, 0, 0);
    cur_req = "R5";
    step(0, 0, 0, 0, 0, 0, 1, 1, 12, 12, 8);
    // R11 write and event in the same cycle
    cur_req = "R11";
    step(1, 1000, 20, 30, 4000, 321, 0, 1, 8, 8, 16);
    step(1, 1000, 20, 30, 4000, 321, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    // R9 R10 fill without reads, keep offering
    cur_req = "R9";
    for (int i = 0; i < DEP + 3; i++) step(1, i * 37, i, 3 * i, 500, i * 11, 0, 0, 0, 0, 0);
    cur_req = "R10";
    idle(3);
    cur_req = "R8";
    for (int i = 0; i < DEP + 2; i++) step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    // R8 R11 random traffic
    for (int i = 0; i < 600; i++) begin
      int wx, wy, wz;
      bit we;
      wx = $urandom % 33;
      wy = $urandom % (33 - wx);
      wz = 32 - wx - wy + (($urandom % 3 == 0) ? 1 : 0);
      we = ($urandom % 10) == 0;
      cur_req = we ? "R11" : "R8";
      step(($urandom % 10) < 7, $urandom % 65536, $urandom % 65536, $urandom % 65536,
           $urandom % 65536, $urandom % 65536, ($urandom % 10) < 6, we, wx, wy, wz);
    end
    cur_req = "R8";
    idle(1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule